// File: doc/BRIEF.md
# Scalar memory request sequencer

This block turns one 64-bit scalar memory instruction into a stream of single-dword memory requests. Along with the instruction word, the issuing stage supplies the base address already read from the base register pair and the value of the register that may hold the offset. The block checks the encoding tag and decodes the opcode into a direction and a dword count. It then picks either the immediate field or the register value as the byte offset. The offset's two low bits are cleared, and the result is added to the base to form the start address.

The block emits one request per cycle on a valid/ready interface. Each request carries the dword address, the scalar register index that the dword belongs to, a write flag and a marker on the final beat. Malformed instructions produce a one-cycle illegal pulse and no requests. A new instruction is taken only while the sequencer is idle.

Top module: `smem_req_seq`

## Requirements
- R1: An instruction whose bits 31:26 differ from 6'b110000 is accepted, and `illegal` is high in the cycle after acceptance. No request is issued for it.
- R2: With a correct tag, an opcode (bits 25:18) outside {0..4, 8..12, 16..18} sets `illegal` in the cycle after acceptance and issues no request.
- R3: When bit 17 is 1, the byte offset is the zero-extended field in bits 51:32. When bit 17 is 0, the byte offset is `in_off_val`.
- R4: The two low bits of the byte offset are cleared, and the first request address is `in_base` plus that aligned offset, modulo 2^48.
- R5: The dword count is 1 shifted left by opcode bits 2:0. This gives opcodes 0-4 and 8-12 counts of 1, 2, 4, 8 and 16, and opcodes 16-18 counts of 1, 2 and 4. Exactly that many requests are issued.
- R6: Beat i carries address start+4*i and register index (bits 12:6 + i) modulo 128.
- R7: `req_write` is 1 for opcodes 16-18 and 0 for the load opcodes.
- R8: Opcodes 8-12 with an odd base-pair field (bit 0 set) are illegal and issue no request. With bit 0 clear, they proceed like plain loads.
- R9: While `req_valid` is high and `req_ready` is low, the request stays valid and the address, index, write flag and last marker hold their values.
- R10: `req_last` is high only on the final beat. After its handshake, `req_valid` drops in the next cycle.
- R11: `in_ready` is low while a burst is outstanding. `in_valid` has no effect then.
- R12: After reset, `req_valid` and `illegal` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Sequencer idle, instruction taken on valid |
| in_instr | input | 64 | Instruction word |
| in_base | input | 48 | Base address read from the base register pair |
| in_off_val | input | 32 | Value of the offset register named by bits 51:32 |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 48 | Dword byte address |
| req_write | output | 1 | 1 for store beats |
| req_dst | output | 7 | Scalar register index of this dword |
| req_last | output | 1 | Final beat of the instruction |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
The main function is exercised with every legal count in both directions, and with immediate and register offsets. Unaligned offset values show whether the low-bit clearing happens. A register field near 127 distinguishes modulo-128 index wrap from overflow. Ready held high, alternating, and gapped in a three-cycle pattern separate true per-handshake stepping from per-cycle stepping. Bad tags, unlisted opcodes, an odd base group on a buffer load, and instructions pushed in during a burst each show whether a request leaks out where none is allowed.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam logic [5:0] ENC_TAG = 6'b110000;

  typedef struct packed {
    logic       legal;
    logic       is_store;
    logic [2:0] cnt_log;
  } op_info_t;

  // Classify an opcode; the base-pair field is needed for the even-group rule.
  function automatic op_info_t op_lookup(input logic [7:0] op, input logic [5:0] sbase);
    op_info_t r;
    r.legal    = 1'b0;
    r.is_store = 1'b0;
    r.cnt_log  = op[2:0];
    if (op <= 8'd4) begin
      r.legal = 1'b1;
    end else if (op >= 8'd8 && op <= 8'd12) begin
      r.legal = ~sbase[0];
    end else if (op >= 8'd16 && op <= 8'd18) begin
      r.legal    = 1'b1;
      r.is_store = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [4:0] beats_of(input logic [2:0] lg);
    return 5'd1 << lg;
  endfunction

  function automatic logic [31:0] dword_align(input logic [31:0] off);
    return {off[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/smem_decode.sv
module smem_decode
  import smem_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFFV_W = 32,
  parameter int IMM_W  = 20,
  parameter int REG_W  = 7,
  parameter int CNT_W  = 5
) (
  input  logic [63:0]       instr,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFV_W-1:0] off_val,
  output logic              legal,
  output logic              is_store,
  output logic [CNT_W-1:0]  beats,
  output logic [ADDR_W-1:0] start_addr,
  output logic [REG_W-1:0]  dst0
);
  logic [5:0]        tag;
  logic [7:0]        opc;
  logic              imm_sel;
  logic [IMM_W-1:0]  imm_off;
  logic [OFFV_W-1:0] eff_off;
  logic [OFFV_W-1:0] al_off;
  op_info_t          info;

  always_comb begin
    tag      = instr[31:26];
    opc      = instr[25:18];
    imm_sel  = instr[17];
    dst0     = instr[12:6];
    imm_off  = instr[32 +: IMM_W];
    info     = op_lookup(opc, instr[5:0]);
    legal    = info.legal && (tag == ENC_TAG);
    is_store = info.is_store;
    beats    = CNT_W'(beats_of(info.cnt_log));
    eff_off  = imm_sel ? OFFV_W'(imm_off) : off_val;
    al_off   = dword_align(eff_off);
    start_addr = base + ADDR_W'(al_off);
  end
endmodule

// File: rtl/smem_burst.sv
module smem_burst #(
  parameter int ADDR_W = 48,
  parameter int REG_W  = 7,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  beats,
  input  logic [REG_W-1:0]  dst0,
  input  logic              is_store,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_dst,
  output logic              req_write,
  output logic              req_last,
  output logic              beat_fire,
  output logic [CNT_W-1:0]  rem_cnt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  dst_q;
  logic              wr_q;
  logic [CNT_W-1:0]  rem_q;

  assign req_valid = busy_q;
  assign req_addr  = addr_q;
  assign req_dst   = dst_q;
  assign req_write = wr_q;
  assign rem_cnt   = rem_q;
  assign req_last  = busy_q && (rem_q == CNT_W'(1));
  assign beat_fire = busy_q && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      dst_q  <= '0;
      wr_q   <= 1'b0;
      rem_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      addr_q <= start_addr;
      dst_q  <= dst0;
      wr_q   <= is_store;
      rem_q  <= beats;
    end else if (beat_fire) begin
      if (req_last) begin
        busy_q <= 1'b0;
      end
      addr_q <= addr_q + STEP;
      dst_q  <= dst_q + REG_W'(1);
      rem_q  <= rem_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/smem_req_seq.sv
module smem_req_seq #(
  parameter int ADDR_W = 48,
  parameter int OFFV_W = 32,
  parameter int IMM_W  = 20,
  parameter int REG_W  = 7,
  parameter int MAX_BEATS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_instr,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [OFFV_W-1:0] in_off_val,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic [REG_W-1:0]  req_dst,
  output logic              req_last,
  output logic              illegal
);
  localparam int CNT_W = $clog2(MAX_BEATS + 1);

  logic              dec_legal;
  logic              dec_store;
  logic [CNT_W-1:0]  dec_beats;
  logic [ADDR_W-1:0] dec_start;
  logic [REG_W-1:0]  dec_dst0;
  logic              acc_fire;
  logic              beat_fire;
  logic [CNT_W-1:0]  rem_cnt;
  logic              ill_q;

  smem_decode #(
    .ADDR_W(ADDR_W), .OFFV_W(OFFV_W), .IMM_W(IMM_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) u_dec (
    .instr(in_instr), .base(in_base), .off_val(in_off_val),
    .legal(dec_legal), .is_store(dec_store), .beats(dec_beats),
    .start_addr(dec_start), .dst0(dec_dst0)
  );

  assign in_ready = ~req_valid;
  assign acc_fire = in_valid && in_ready;

  smem_burst #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(acc_fire && dec_legal),
    .start_addr(dec_start), .beats(dec_beats), .dst0(dec_dst0),
    .is_store(dec_store), .req_ready(req_ready), .req_valid(req_valid),
    .req_addr(req_addr), .req_dst(req_dst), .req_write(req_write),
    .req_last(req_last), .beat_fire(beat_fire), .rem_cnt(rem_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= acc_fire && !dec_legal;
  end
  assign illegal = ill_q;
endmodule

// File: rtl/smem_req_seq_chk.sv
module smem_req_seq_chk #(
  parameter int ADDR_W = 48,
  parameter int REG_W  = 7,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [REG_W-1:0]  req_dst,
  input logic              req_write,
  input logic              req_last,
  input logic              illegal,
  input logic              acc_fire,
  input logic              dec_legal,
  input logic              beat_fire,
  input logic [CNT_W-1:0]  rem_cnt
);
  p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !req_valid);
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && dec_legal |=> req_valid && !illegal);
  p_rem_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> rem_cnt != '0);
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !req_last |=> req_valid && req_addr == $past(req_addr) + ADDR_W'(4));
  p_dst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !req_last |=> req_dst == $past(req_dst) + REG_W'(1));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_dst)
      && $stable(req_write) && $stable(req_last));
  p_last_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && req_last |=> !req_valid);
  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);
endmodule

bind smem_req_seq smem_req_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_dst(req_dst),
  .req_write(req_write), .req_last(req_last), .illegal(illegal),
  .acc_fire(acc_fire), .dec_legal(dec_legal), .beat_fire(beat_fire),
  .rem_cnt(rem_cnt)
);

// File: tb/smem_req_seq_tb.sv
module smem_req_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_instr = '0;
  logic [47:0] in_base = '0;
  logic [31:0] in_off_val = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [47:0] req_addr;
  logic        req_write;
  logic [6:0]  req_dst;
  logic        req_last;
  logic        illegal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smem_req_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_base(in_base), .in_off_val(in_off_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_dst(req_dst), .req_last(req_last),
    .illegal(illegal)
  );

  function automatic logic [63:0] mk(input logic [7:0] op, input bit imm,
      input logic [6:0] sd, input logic [5:0] sb, input logic [19:0] off,
      input logic [5:0] tag = 6'b110000);
    logic [63:0] w = '0;
    w[31:26] = tag; w[25:18] = op; w[17] = imm;
    w[12:6] = sd; w[5:0] = sb; w[51:32] = off;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string msg,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic present(input logic [63:0] w, input logic [47:0] b, input logic [31:0] ov);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_instr = w; in_base = b; in_off_val = ov; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Present a legal instruction and check each beat. mode: 0 ready always,
  // 1 alternate, 2 gap every third cycle. noise keeps in_valid high meanwhile.
  task automatic run_burst(input string req, input logic [63:0] w,
      input logic [47:0] b, input logic [31:0] ov, input int nbeats,
      input bit wr, input int mode, input bit noise = 1'b0);
    logic [31:0] off;
    logic [47:0] start;
    int i = 0;
    int cyc = 0;
    bit rdy;
    bit fin = 1'b0;
    off = w[17] ? {12'd0, w[51:32]} : ov;
    off[1:0] = 2'b00;
    start = b + {16'd0, off};
    present(w, b, ov);
    if (noise) begin
      in_instr = mk(8'd5, 1'b1, 7'd0, 6'd0, 20'd0, 6'b000001);
      in_valid = 1'b1;
    end
    while (!fin && cyc < 200) begin
      if (!req_valid) begin
        check(1'b0, req, "request missing", 64'(i), 64'(nbeats));
        fin = 1'b1;
      end else begin
        check(req_addr == start + 48'(4 * i) && req_dst == 7'(w[12:6] + 7'(i))
              && req_write == wr && req_last == (i == nbeats - 1)
              && illegal == 1'b0 && in_ready == 1'b0,
              req, $sformatf("beat %0d addr/dst/write/last", i),
              {8'(req_dst), 4'(req_write), 4'(req_last), req_addr},
              {8'(w[12:6] + 7'(i)), 4'(wr), 4'(i == nbeats - 1), start + 48'(4 * i)});
        rdy = (mode == 0) || (mode == 1 && cyc[0]) || (mode == 2 && (cyc % 3) != 0);
        req_ready = rdy;
        if (rdy && req_last) begin
          fin = 1'b1;
          in_valid = 1'b0;
        end
        if (rdy) i++;
      end
      cyc++;
      @(negedge clk);
    end
    req_ready = 1'b0;
    check(i == nbeats, req, "beat count", 64'(i), 64'(nbeats));
    check(!req_valid && in_ready && !illegal, "R10", "idle after last",
          {62'd0, req_valid, in_ready}, 64'd1);
  endtask

  task automatic run_illegal(input string req, input logic [63:0] w);
    present(w, 48'h1000, 32'd0);
    check(illegal && !req_valid, req, "illegal pulse, no request",
          {62'd0, illegal, req_valid}, 64'd2);
    req_ready = 1'b1;
    @(negedge clk);
    check(!illegal && !req_valid && in_ready, req, "quiet after reject",
          {61'd0, illegal, req_valid, in_ready}, 64'd1);
    req_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!req_valid && !illegal && in_ready, "R12", "reset state",
          {61'd0, req_valid, illegal, in_ready}, 64'd1);
  endtask

  task automatic t_loads();
    run_burst("R3", mk(8'd0, 1'b1, 7'd5, 6'd2, 20'h00013), 48'h0000_1234_5600, 32'hFFFF_FFFF, 1, 1'b0, 0);
    run_burst("R4", mk(8'd1, 1'b0, 7'd10, 6'd4, 20'd7), 48'h0000_0000_1000, 32'h0000_0107, 2, 1'b0, 0);
    run_burst("R5", mk(8'd2, 1'b1, 7'd20, 6'd0, 20'hFFFFF), 48'h0000_8000_0000, 32'd0, 4, 1'b0, 1);
    run_burst("R5", mk(8'd3, 1'b0, 7'd64, 6'd6, 20'd3), 48'hFFFF_FFFF_FFF0, 32'h0000_0022, 8, 1'b0, 2);
    run_burst("R6", mk(8'd4, 1'b1, 7'd120, 6'd8, 20'h00400), 48'h0000_0002_0000, 32'd0, 16, 1'b0, 2);
  endtask

  task automatic t_stores();
    run_burst("R7", mk(8'd16, 1'b1, 7'd1, 6'd2, 20'h00008), 48'h0000_0000_4000, 32'd0, 1, 1'b1, 0);
    run_burst("R7", mk(8'd17, 1'b0, 7'd2, 6'd2, 20'd0), 48'h0000_0000_4000, 32'h0000_0031, 2, 1'b1, 1);
    run_burst("R9", mk(8'd18, 1'b1, 7'd3, 6'd2, 20'h00010), 48'h0000_0000_4000, 32'd0, 4, 1'b1, 2);
  endtask

  task automatic t_buffer();
    run_burst("R8", mk(8'd10, 1'b1, 7'd30, 6'd4, 20'h00020), 48'h0000_0000_9000, 32'd0, 4, 1'b0, 0);
    run_burst("R8", mk(8'd12, 1'b1, 7'd40, 6'd6, 20'h00000), 48'h0000_0000_9000, 32'd0, 16, 1'b0, 1);
    run_illegal("R8", mk(8'd9, 1'b1, 7'd0, 6'd5, 20'd0));
  endtask

  task automatic t_illegal();
    run_illegal("R1", mk(8'd0, 1'b1, 7'd0, 6'd0, 20'd0, 6'b110001));
    run_illegal("R1", mk(8'd2, 1'b1, 7'd0, 6'd0, 20'd0, 6'b010000));
    run_illegal("R2", mk(8'd5, 1'b1, 7'd0, 6'd0, 20'd0));
    run_illegal("R2", mk(8'd19, 1'b1, 7'd0, 6'd0, 20'd0));
    run_illegal("R2", mk(8'd32, 1'b1, 7'd0, 6'd0, 20'd0));
  endtask

  task automatic t_busy();
    run_burst("R11", mk(8'd2, 1'b1, 7'd50, 6'd0, 20'h00100), 48'h0000_0000_0000, 32'd0, 4, 1'b0, 1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loads();
    t_stores();
    t_buffer();
    t_illegal();
    t_busy();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule